// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes a single memory request for a whole warp. The request holds one byte address for each of 32 lanes and an active-lane mask. The block turns it into as few memory transactions as possible, each one covering a single aligned 128-byte line. Every transaction carries the line's base address and a bitmask of the lanes whose addresses fall inside that line.

The transactions leave one at a time on a valid/ready port toward the memory system. Once the last one has been accepted, the block raises a one-cycle completion pulse. With that pulse it reports how many transactions the request needed. Each lane is expected to access a 4-byte word. An aligned run of 32 consecutive words therefore costs one transaction, and the same run started off a line boundary costs two.

A new warp request is taken only when the block is idle, which happens in the cycle after the previous completion. The transaction port keeps its value for as long as the downstream side holds ready low.

Top module: `warp_coalescer`

## Requirements
- R1: While reset is held and in the first cycle after it, `txn_valid` and `done` are 0 and `req_ready` is 1.
- R2: Each transaction address equals an active lane's byte address with bits [6:0] cleared, so every transaction names an aligned 128-byte line.
- R3: Bit i of `txn_lanes` stands for lane i. Across one request, every active lane appears in exactly one transaction and inactive lanes appear in none.
- R4: A request produces exactly one transaction per distinct line among its active lanes. 32 aligned consecutive 4-byte words give 1 transaction, and the same run starting 4 bytes past a boundary gives 2.
- R5: Transactions come out ordered by the lowest-numbered active lane not yet served. Each one carries every remaining active lane in that lane's line.
- R6: `done` is high for exactly one cycle, the cycle after the handshake of the last transaction. In that cycle `txn_count` equals the number of transactions issued, from 1 to 32.
- R7: An all-zero active mask issues no transaction. `done` rises in the cycle after the request is accepted, with `txn_count` 0.
- R8: `req_ready` is low from the cycle after a request is accepted up to and including its `done` cycle. `req_valid`, `req_addr` and `req_mask` driven during that time have no effect on the transactions.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_addr` and `txn_lanes` stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_mask | input | 32 | Active lanes, bit i = lane i |
| txn_valid | output | 1 | Transaction offered downstream |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_addr | output | 32 | Aligned line base address |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle completion pulse |
| txn_count | output | 6 | Transactions used by the request, valid with done |

## Verification
Suppose the pending-lane state is wrong, for example a lane is never cleared or is cleared by the wrong transaction. The port shows it at the very next handshake: a lane mask comes out duplicated or missing, or out of order. The request then either never completes or completes with a `txn_count` that does not match the number of distinct lines. A wrong leader choice or a wrong line compare shows at once as a transaction address or lane mask that differs from what is computed for the lowest remaining lane. A state machine that leaves busy at the wrong time shows as an early or doubled `done`, or as `req_ready` rising while transactions are still pending.

// File: rtl/coal_pkg.sv
package coal_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coal_state_t;
endpackage

// File: rtl/coal_lead_pick.sv
module coal_lead_pick #(
  parameter int LANES  = 32,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  pend,
  output logic [LANE_W-1:0] lead_idx,
  output logic              any
);
  always_comb begin
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) lead_idx = LANE_W'(i);
    end
    any = |pend;
  end
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 7,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic [LANES*ADDR_W-1:0] addr,
  input  logic [LANES-1:0]        pend,
  input  logic [TAG_W-1:0]        lead_tag,
  output logic [LANES-1:0]        hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = pend[g] && (addr[g*ADDR_W+OFF_W +: TAG_W] == lead_tag);
  end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int LANE_W = $clog2(LANES),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_mask,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [LANES-1:0]        txn_lanes,
  output logic                    done,
  output logic [CNT_W-1:0]        txn_count
);

  coal_state_t             state_q, state_d;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES-1:0]        pend_q, pend_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    addr_en;

  logic [LANE_W-1:0] lead_idx;
  logic              any_pend;
  logic [TAG_W-1:0]  lead_tag;
  logic [LANES-1:0]  hit;
  logic              accept, fire;

  coal_lead_pick #(.LANES(LANES)) u_pick (
    .pend     (pend_q),
    .lead_idx (lead_idx),
    .any      (any_pend)
  );

  assign lead_tag = addr_q[32'(lead_idx)*ADDR_W+OFF_W +: TAG_W];

  coal_line_match #(.LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_match (
    .addr     (addr_q),
    .pend     (pend_q),
    .lead_tag (lead_tag),
    .hit      (hit)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign txn_valid = (state_q == ST_BUSY) && any_pend;
  assign txn_addr  = {lead_tag, {OFF_W{1'b0}}};
  assign txn_lanes = hit;
  assign done      = (state_q == ST_BUSY) && !any_pend;
  assign txn_count = cnt_q;

  assign accept  = req_valid && req_ready;
  assign fire    = txn_valid && txn_ready;
  assign addr_en = accept;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_BUSY;
          pend_d  = req_mask;
          cnt_d   = '0;
        end
      end
      ST_BUSY: begin
        if (!any_pend) begin
          state_d = ST_IDLE;
        end else if (fire) begin
          pend_d = pend_q & ~hit;
          cnt_d  = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= req_addr;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_addr) && $stable(txn_lanes)));

  // R3
  lanes_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_lanes != '0) && ((txn_lanes & ~pend_q) == '0)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txn_valid && (txn_count <= CNT_W'(LANES))));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  served_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && txn_ready) |=> ((pend_q & $past(txn_lanes)) == '0));

endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 32;
  localparam int ADDR_W = 32;

  logic                    clk;
  logic                    rst_n;
  logic                    req_valid;
  logic                    req_ready;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic [LANES-1:0]        req_mask;
  logic                    txn_valid;
  logic                    txn_ready;
  logic [ADDR_W-1:0]       txn_addr;
  logic [LANES-1:0]        txn_lanes;
  logic                    done;
  logic [5:0]              txn_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] a [LANES];

  warp_coalescer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_mask  (req_mask),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_addr  (txn_addr),
    .txn_lanes (txn_lanes),
    .done      (done),
    .txn_count (txn_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "WDOG", "watchdog expired", 64'(cycles), 64'd150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_req(input string name, input logic [LANES-1:0] m,
                         input bit stall, input bit poke);
    logic [31:0]      exp_addr [LANES];
    logic [LANES-1:0] exp_lanes [LANES];
    logic [LANES-1:0] rem, grp;
    logic [LANES*ADDR_W-1:0] packed_a;
    logic [31:0]      s_addr;
    logic [LANES-1:0] s_lanes;
    logic [LANES-1:0] seen;
    int n_exp, k, cyc, lead;
    bit toggle, prev_st, got_done;
    n_exp = 0;
    rem = m;
    while (rem != '0) begin
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (rem[i]) lead = i;
      grp = '0;
      for (int j = 0; j < LANES; j++)
        if (rem[j] && (a[j][31:7] == a[lead][31:7])) grp[j] = 1'b1;
      exp_addr[n_exp]  = {a[lead][31:7], 7'd0};
      exp_lanes[n_exp] = grp;
      n_exp++;
      rem = rem & ~grp;
    end
    for (int i = 0; i < LANES; i++) packed_a[i*ADDR_W +: ADDR_W] = a[i];

    @(negedge clk);
    chk(req_ready == 1'b1, "R8", {name, " ready when idle"}, 64'(req_ready), 64'd1);
    req_addr  = packed_a;
    req_mask  = m;
    req_valid = 1'b1;
    @(negedge clk);
    if (poke) begin
      req_addr = ~packed_a;
      req_mask = ~m;
    end else begin
      req_valid = 1'b0;
    end
    k = 0; cyc = 0; toggle = 0; prev_st = 0; got_done = 0; seen = '0;
    s_addr = '0; s_lanes = '0;
    while (!got_done && cyc < 300) begin
      if (prev_st) begin
        chk(txn_valid && txn_addr == s_addr && txn_lanes == s_lanes, "R9",
            {name, " held under stall"}, {txn_addr, txn_lanes}, {s_addr, s_lanes});
      end
      if (!done) begin
        chk(req_ready == 1'b0, "R8", {name, " busy not ready"}, 64'(req_ready), 64'd0);
      end
      if (done) begin
        got_done = 1;
        txn_ready = 1'b0;
        req_valid = 1'b0;
        if (m == '0) begin
          chk(k == 0 && cyc == 0, "R7", {name, " empty mask immediate done"},
              64'(k * 1000 + cyc), 64'd0);
          chk(txn_count == 6'd0, "R7", {name, " empty count"}, 64'(txn_count), 64'd0);
        end else begin
          chk(k == n_exp, "R4", {name, " transaction total"}, 64'(k), 64'(n_exp));
          chk(txn_count == 6'(n_exp), "R6", {name, " reported count"},
              64'(txn_count), 64'(n_exp));
          chk(seen == m, "R3", {name, " lanes covered"}, 64'(seen), 64'(m));
        end
        chk(txn_valid == 1'b0, "R6", {name, " no valid with done"}, 64'(txn_valid), 64'd0);
      end else if (txn_valid) begin
        if (stall && !toggle) begin
          txn_ready = 1'b0;
          prev_st = 1;
          s_addr = txn_addr;
          s_lanes = txn_lanes;
        end else begin
          txn_ready = 1'b1;
          prev_st = 0;
          if (k < n_exp) begin
            chk(txn_addr == exp_addr[k], "R2", {name, " line address"},
                64'(txn_addr), 64'(exp_addr[k]));
            chk(txn_lanes == exp_lanes[k], "R5", {name, " lane group order"},
                64'(txn_lanes), 64'(exp_lanes[k]));
          end else begin
            chk(1'b0, "R4", {name, " extra transaction"}, 64'(k + 1), 64'(n_exp));
          end
          chk((seen & txn_lanes) == '0, "R3", {name, " lane served once"},
              64'(seen & txn_lanes), 64'd0);
          seen = seen | txn_lanes;
          k++;
        end
        toggle = !toggle;
      end else begin
        txn_ready = 1'b0;
        prev_st = 0;
      end
      if (!got_done) begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!got_done) chk(1'b0, "R6", {name, " done never seen"}, 64'(cyc), 64'd300);
    @(negedge clk);
    chk(done == 1'b0, "R6", {name, " done single cycle"}, 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R8", {name, " idle after done"}, 64'(req_ready), 64'd1);
    txn_ready = 1'b0;
  endtask

  task automatic test_aligned();
    for (int i = 0; i < LANES; i++) a[i] = 32'h4000 + 32'(4 * i);
    run_req("aligned", '1, 0, 0);
  endtask

  task automatic test_misaligned();
    for (int i = 0; i < LANES; i++) a[i] = 32'h4004 + 32'(4 * i);
    run_req("misaligned", '1, 0, 0);
  endtask

  task automatic test_stride_line();
    for (int i = 0; i < LANES; i++) a[i] = 32'h10000 + 32'(128 * i) + 32'(i % 7);
    run_req("stride128", '1, 1, 0);
  endtask

  task automatic test_reverse_groups();
    for (int i = 0; i < LANES; i++) a[i] = 32'h8000 + 32'(((31 - i) / 4) * 128) + 32'(4 * (i % 4));
    run_req("reverse", 32'hF0F0_5A5A, 0, 0);
  endtask

  task automatic test_interleave_poke();
    for (int i = 0; i < LANES; i++)
      a[i] = (i % 2 == 1) ? 32'h2000 + 32'(i) : 32'h9000 + 32'(4 * i);
    run_req("interleave", 32'hFFFF_FFFE, 1, 1);
  endtask

  task automatic test_empty();
    for (int i = 0; i < LANES; i++) a[i] = 32'h100 * 32'(i);
    run_req("empty", '0, 0, 1);
  endtask

  task automatic test_single();
    for (int i = 0; i < LANES; i++) a[i] = 32'hABC0_0000 + 32'(8 * i);
    run_req("single", 32'h8000_0000, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_mask = '0;
    txn_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(txn_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1", "outputs in reset",
        {61'd0, txn_valid, done, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txn_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1, "R1", "outputs after reset",
        {61'd0, txn_valid, done, req_ready}, 64'd1);
    test_aligned();
    test_misaligned();
    test_stride_line();
    test_reverse_groups();
    test_interleave_poke();
    test_empty();
    test_single();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule